// File: doc/BRIEF.md
# Transmit Path Guard Controller

This block supervises whether a node may drive a shared single-wire bus. Each clock it samples the bit the node wants to send (`tx_data`) and the synchronized level it reads back from the bus (`bus_lvl`). It holds one state bit that grants or withholds the driver enable. Two faults withdraw the grant. The first is a transmitted bit that disagrees with the bus for too long. The second is a transmit line that stays low for too long.

Once the grant is withdrawn, it returns only after the transmit bit and the bus have both been high for a qualifying number of cycles. An external override pair can force the grant on or off, and suspends both fault checks while it is applied. The status pin reports the state of the path. All time limits are parameters counted in clock cycles.

The block carries no data stream. Every pin is a plain level sampled or updated on the rising clock edge, so there is no valid/ready handshake and no back-pressure.

Top module: `tx_guard`

## Requirements
- R1: While reset is asserted and after it is released, the path is disabled: `drv_en`=0 and `tx_blocked`=1 until an enable condition or an override occurs.
- R2: While disabled and not overridden, the path becomes enabled at the clock edge that samples `tx_data`=1 and `bus_lvl`=1 for the ENA_CYC-th consecutive time. A shorter run of both-high samples leaves it disabled.
- R3: While enabled and not overridden, if `tx_data`≠`bus_lvl` is sampled on CMP_CYC+1 consecutive edges, the path is disabled at the last of those edges. A mismatch lasting CMP_CYC cycles or fewer has no effect.
- R4: While enabled and not overridden, the path is disabled at the edge where the count of low `tx_data` samples reaches LOW_CYC. Counting starts at the first low sample after a clear. After LOW_CYC-1 low samples, the path is still enabled.
- R5: A run of at least REC_CYC consecutive high `tx_data` samples clears the low count to zero.
- R6: A high run shorter than REC_CYC leaves the low count unchanged, and low samples after it add to the earlier total.
- R7: `tx_blocked` is 1 exactly when the path is disabled. It is always the complement of `drv_en`.
- R8: When `ovr_vld`=1 is sampled, the next state is enabled if `ovr_val`=0 and disabled if `ovr_val`=1. Mismatch, low-timeout and enable conditions are ignored while `ovr_vld`=1.
- R9: After `ovr_vld` returns to 0, the path keeps its last state. All counters start from zero, so a subsequent fault needs its full length again.
- R10: An override sampled in the same cycle as a bit-compare trip or an enable completion takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Bit the node wants to transmit |
| bus_lvl | input | 1 | Synchronized bus readback level |
| ovr_val | input | 1 | Override value: 0 force enable, 1 force disable |
| ovr_vld | input | 1 | Override applied when 1 |
| drv_en | output | 1 | Bus driver enable |
| tx_blocked | output | 1 | Status: 1 when the transmit path is disabled |

## Verification
The most delicate collisions are an override and a fault trip landing on the same edge, and an override and an enable completion landing on the same edge. The bench builds a mismatch run to exactly CMP_CYC samples and applies a force-on on the cycle that would have tripped. It also builds a both-high run to ENA_CYC-1 samples and applies a force-off on the completing cycle. In each case the state after the edge must follow the override (R10). Once the override is released, the full mismatch length must be needed again (R9). Sweeps over run lengths on both sides of each threshold judge the trip and recovery edges arithmetically from the parameters.

// File: rtl/tx_guard_pkg.sv
package tx_guard_pkg;
  typedef enum logic {
    PATH_OFF = 1'b0,
    PATH_ON  = 1'b1
  } path_state_t;
endpackage

// File: rtl/tx_guard_run_cnt.sv
// Counts consecutive cycles with cond=1. hit marks the LIMIT-th one.
module tx_guard_run_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cond,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM    = W'(LIMIT);
  localparam logic [W-1:0] LIM_M1 = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr)       cnt_q <= '0;
    else if (!cond)     cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = !clr && cond && (cnt_q >= LIM_M1);

  a_r2_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  a_r9_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tx_guard_low_timer.sv
// Accumulates low transmit samples; cleared by a qualified recovery run.
module tx_guard_low_timer #(
  parameter int LOW_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tx_low,
  input  logic rec_done,
  output logic expired
);
  localparam int W = $clog2(LOW_CYC + 1);
  localparam logic [W-1:0] LIM    = W'(LOW_CYC);
  localparam logic [W-1:0] LIM_M1 = W'(LOW_CYC - 1);

  logic [W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_q <= '0;
    else if (clr || rec_done)   acc_q <= '0;
    else if (tx_low && acc_q != LIM) acc_q <= acc_q + 1'b1;
  end

  assign expired = !clr && tx_low && (acc_q >= LIM_M1);

  a_r4_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= LIM);
  a_r6_hold_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_low && !rec_done && !clr) |=> $stable(acc_q));
  a_r5_rec_only_high: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> !tx_low);
endmodule

// File: rtl/tx_guard.sv
module tx_guard
  import tx_guard_pkg::*;
#(
  parameter int CMP_CYC = 16,
  parameter int ENA_CYC = 8,
  parameter int LOW_CYC = 1000,
  parameter int REC_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_data,
  input  logic bus_lvl,
  input  logic ovr_val,
  input  logic ovr_vld,
  output logic drv_en,
  output logic tx_blocked
);
  path_state_t path_q;
  logic cmp_hit, ena_hit, rec_hit, low_exp;

  tx_guard_run_cnt #(.LIMIT(CMP_CYC + 1)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(ovr_vld),
    .cond(tx_data != bus_lvl), .hit(cmp_hit));

  tx_guard_run_cnt #(.LIMIT(ENA_CYC)) u_ena (
    .clk(clk), .rst_n(rst_n), .clr(ovr_vld),
    .cond(tx_data && bus_lvl), .hit(ena_hit));

  tx_guard_run_cnt #(.LIMIT(REC_CYC)) u_rec (
    .clk(clk), .rst_n(rst_n), .clr(ovr_vld),
    .cond(tx_data), .hit(rec_hit));

  tx_guard_low_timer #(.LOW_CYC(LOW_CYC)) u_low (
    .clk(clk), .rst_n(rst_n), .clr(ovr_vld),
    .tx_low(!tx_data), .rec_done(rec_hit), .expired(low_exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 path_q <= PATH_OFF;
    else if (ovr_vld)                           path_q <= ovr_val ? PATH_OFF : PATH_ON;
    else if (path_q == PATH_ON && (cmp_hit || low_exp)) path_q <= PATH_OFF;
    else if (path_q == PATH_OFF && ena_hit)     path_q <= PATH_ON;
  end

  assign drv_en     = (path_q == PATH_ON);
  assign tx_blocked = (path_q == PATH_OFF);

  a_r8_force_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_vld && !ovr_val) |=> drv_en);
  a_r8_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_vld && ovr_val) |=> tx_blocked);
  a_r3_cmp_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_vld && drv_en && cmp_hit) |=> !drv_en);
  a_r2_need_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_vld && !drv_en && !(tx_data && bus_lvl)) |=> !drv_en);
  a_r7_status: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({drv_en, tx_blocked}) == 1);
endmodule

// File: tb/tx_guard_bench.sv
module tx_guard_bench;
  localparam int CMP = 3;
  localparam int ENA = 4;
  localparam int LOW = 10;
  localparam int REC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_data = 1'b1, bus_lvl = 1'b1, ovr_val = 1'b0, ovr_vld = 1'b0;
  logic drv_en, tx_blocked;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tx_guard #(.CMP_CYC(CMP), .ENA_CYC(ENA), .LOW_CYC(LOW), .REC_CYC(REC)) u_tx_guard (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .bus_lvl(bus_lvl),
    .ovr_val(ovr_val), .ovr_vld(ovr_vld), .drv_en(drv_en), .tx_blocked(tx_blocked));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected enabled state; R7 complement checked each time
  task automatic chk_on(input logic exp, input string tag);
    chk(drv_en, exp, tag);
    chk(tx_blocked, !drv_en, "R7 status complement");
  endtask

  task automatic cyc(input logic t, input logic b, input logic v, input logic o);
    tx_data = t; bus_lvl = b; ovr_vld = v; ovr_val = o;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic force_off();
    cyc(1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic bring_up();
    for (int i = 0; i < ENA; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_on(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_on(1'b0, "R1 after reset");

    // R2: both-high run length sweep
    for (int l = 1; l <= ENA + 1; l++) begin
      for (int i = 0; i < l; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
      chk_on(l >= ENA, $sformatf("R2 high run %0d", l));
      force_off();
      chk_on(1'b0, "R8 force off");
    end

    // R3: mismatch length sweep, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int l = 1; l <= CMP + 2; l++) begin
        bring_up();
        chk_on(1'b1, "R2 bring up");
        for (int i = 0; i < l; i++) cyc(pol == 0, pol != 0, 1'b0, 1'b0);
        chk_on(!(l > CMP), $sformatf("R3 mismatch %0d pol %0d", l, pol));
        force_off();
      end
    end

    // R4: constant-low boundary
    for (int l = LOW - 1; l <= LOW; l++) begin
      bring_up();
      for (int i = 0; i < l; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
      chk_on(!(l >= LOW), $sformatf("R4 low run %0d", l));
      force_off();
    end

    // R5/R6: high pulse width between low runs
    for (int p = 1; p <= REC + 1; p++) begin
      bring_up();
      for (int i = 0; i < LOW - 2; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
      chk_on(1'b1, "R4 before timeout");
      for (int i = 0; i < p; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      chk_on(p >= REC, p >= REC ? $sformatf("R5 pulse %0d clears", p)
                                : $sformatf("R6 pulse %0d keeps count", p));
      force_off();
    end

    // R8: force on with mismatching inputs; checks suppressed
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    chk_on(1'b1, "R8 force on");
    for (int i = 0; i < CMP + 3; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0);
    chk_on(1'b1, "R8 mismatch ignored");
    for (int i = 0; i < LOW + 2; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk_on(1'b1, "R8 low timeout ignored");
    for (int i = 0; i < ENA + 2; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1);
    chk_on(1'b0, "R8 enable ignored under force off");
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk_on(1'b0, "R9 off kept after release");

    // R10: force-on on the cycle a mismatch trip would occur
    force_off();
    bring_up();
    for (int i = 0; i < CMP; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk_on(1'b1, "R3 at threshold");
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    chk_on(1'b1, "R10 override beats trip");
    for (int i = 0; i < CMP; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk_on(1'b1, "R9 count restarted");
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk_on(1'b0, "R9 full length trips");

    // R10: force-off on the cycle enable would complete
    force_off();
    for (int i = 0; i < ENA - 1; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 1'b1);
    chk_on(1'b0, "R10 override beats enable");
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk_on(1'b0, "R9 enable run restarted");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule